// File: doc/BRIEF.md
# Opcode Fetch and Load/Store Sequencer

This block is the control core of a small 8-bit processor with a 16-bit address space. It holds the program counter. It fetches one opcode byte at a time from a byte-wide synchronous memory that returns read data one cycle after the address. It carries out the data-movement part of the instruction set itself:

- immediate loads of one byte into a register;
- immediate loads of two bytes into a register pair or into the 16-bit address register;
- indirect loads through the address register;
- stores through the address register;
- register-to-register copies.

Opcodes that belong to other units (arithmetic, branches, port I/O, compare, stack, flag clear, address-register transfer) take one byte and have no effect here. Reserved opcodes raise a one-cycle strobe. The halt opcode stops the block until the next reset.

The register file lives outside the block. The sequencer drives a read index and receives the read data combinationally. It writes through a single write port. The register indices are F=0, S=1, X=2, Y=3, A=4, B=5, C=6, D=7.

Top module: `seq_fetch_load`

## Requirements
- R1: A synchronous active-high reset clears the PC to 0x0000 and the address register to 0x0000. After reset the block presents address 0x0000 for an opcode fetch, with busy, halted, illegal and both write enables low.
- R2: Every byte read through the PC (opcode or immediate) advances the PC by one. The PC goes from 0xFFFF to 0x0000 with no indication.
- R3: Opcode 0000_0rrr writes the next byte to register rrr. The following opcode is fetched from the byte after that.
- R4: Opcode 0000_1rrr reads memory at the address register and writes the byte to register rrr. It advances the PC only for the opcode itself.
- R5: Opcode 0001_00pp with pp = 00, 01 or 10 reads two following bytes. The first goes to the high register (A, C or X) and the second to the low register (B, D or Y).
- R6: Opcode 0001_0011 loads the address register from two following bytes, the first byte becoming bits 15:8.
- R7: Opcode 0010_1rrr writes register rrr to memory at the address register. It issues exactly one memory write and no register write.
- R8: Opcode 01qq_qrrr copies register qqq into register rrr, including the case qqq = rrr.
- R9: Opcode 0xFF raises halted. From then until reset there are no further fetches and no writes, and the memory address stays constant.
- R10: Reserved opcodes pulse illegal for one cycle with no write, and the next byte is fetched as an opcode. The reserved opcodes are 0001_01xx, 0001_1xxx, 10xx_xxxx, 1100_xxxx, 1101_0xxx, 1101_11xx and 1111_110x.
- R11: The opcodes 0010_0xxx, 0011_xxxx, 1101_10xx, 1110_xxxx, 1111_0xxx, 1111_10xx and 0xFE are one-byte no-ops that write nothing and do not pulse illegal.
- R12: Busy is low in exactly the cycles in which an opcode address is presented and the block is not halted. The number of such cycles equals the number of instructions started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Memory write enable |
| rf_raddr | output | 3 | Register-file read index |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write enable |
| busy | output | 1 | An instruction is in progress |
| halted | output | 1 | Halt opcode executed |
| illegal | output | 1 | One-cycle strobe on a reserved opcode |

## Verification
The hardest case to reach is the silent wrap of the program counter. It needs an instruction whose bytes straddle 0xFFFF and 0x0000, which a program can only reach by running through the whole address space. The bench fills memory with back-to-back wide immediate loads. These consume three bytes in four cycles and place a one-byte immediate load at 0xFFFF. Its operand is then the opcode byte stored at 0x0000, so both the loaded value and the next fetch address at 0x0001 show the wrap.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] REG_X = 3'd2;
    localparam logic [REG_IDX_W-1:0] REG_A = 3'd4;
    localparam logic [REG_IDX_W-1:0] REG_C = 3'd6;

    localparam logic [1:0] PAIR_ADR = 2'b11;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPHI,
        ST_OPLO,
        ST_EXEC,
        ST_HALT
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_LDI,
        OP_LDIND,
        OP_LDW,
        OP_SAVE,
        OP_MOVE,
        OP_HALT,
        OP_RSVD
    } op_kind_e;

    typedef struct packed {
        op_kind_e                 kind;
        logic [REG_IDX_W-1:0]     dst;
        logic [REG_IDX_W-1:0]     src;
        logic [1:0]               pair;
    } op_info_t;

    function automatic logic [REG_IDX_W-1:0] pair_hi_idx(input logic [1:0] p);
        case (p)
            2'd0:    return REG_A;
            2'd1:    return REG_C;
            default: return REG_X;
        endcase
    endfunction

    function automatic logic [REG_IDX_W-1:0] pair_lo_idx(input logic [1:0] p);
        return pair_hi_idx(p) + 3'd1;
    endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);
    always_comb begin
        info.dst  = opcode[2:0];
        info.src  = opcode[5:3];
        info.pair = opcode[1:0];
        casez (opcode)
            8'b0000_0???: info.kind = OP_LDI;
            8'b0000_1???: info.kind = OP_LDIND;
            8'b0001_00??: info.kind = OP_LDW;
            8'b0010_0???: info.kind = OP_NOP;
            8'b0010_1???: info.kind = OP_SAVE;
            8'b0011_????: info.kind = OP_NOP;
            8'b01??_????: info.kind = OP_MOVE;
            8'b1101_10??: info.kind = OP_NOP;
            8'b1110_????: info.kind = OP_NOP;
            8'b1111_0???: info.kind = OP_NOP;
            8'b1111_10??: info.kind = OP_NOP;
            8'b1111_1110: info.kind = OP_NOP;
            8'b1111_1111: info.kind = OP_HALT;
            default:      info.kind = OP_RSVD;
        endcase
        // store source is the low field, move source the middle field
        if (opcode[7:6] != 2'b01) info.src = opcode[2:0];
    end
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst)      pc <= '0;
        else if (inc) pc <= pc + 1'b1;
    end

    // R2: one step per byte read, modulo 2^W
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        inc |=> pc == $past(pc) + 1'b1);

    // R4: no advance when no byte is read through the PC
    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(pc));
endmodule

// File: rtl/seq_fetch_load.sv
module seq_fetch_load
    import seq_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int ADDR_W = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 mem_we,
    output logic [REG_IDX_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0]    rf_rdata,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 rf_we,
    output logic                 busy,
    output logic                 halted,
    output logic                 illegal
);
    localparam int HALF_W = ADDR_W / 2;

    seq_state_e           state, state_nx;
    op_info_t             dec;
    op_kind_e             ir_kind;
    logic [REG_IDX_W-1:0] ir_dst;
    logic [1:0]           ir_pair;
    logic [ADDR_W-1:0]    pc, adr;
    logic                 pc_inc, adr_hi_ld, adr_lo_ld;

    seq_decode u_dec (.opcode(mem_rdata[BYTE_W-1:0]), .info(dec));

    seq_pc #(.W(ADDR_W)) u_pc (.clk(clk), .rst(rst), .inc(pc_inc), .pc(pc));

    always_comb begin
        state_nx  = state;
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = rf_rdata;
        rf_raddr  = dec.src;
        rf_we     = 1'b0;
        rf_waddr  = ir_dst;
        rf_wdata  = mem_rdata;
        pc_inc    = 1'b0;
        illegal   = 1'b0;
        adr_hi_ld = 1'b0;
        adr_lo_ld = 1'b0;
        case (state)
            ST_FETCH: begin
                pc_inc   = 1'b1;
                state_nx = ST_DECODE;
            end
            ST_DECODE: begin
                state_nx = ST_FETCH;
                case (dec.kind)
                    OP_LDI: begin
                        pc_inc   = 1'b1;
                        state_nx = ST_OPLO;
                    end
                    OP_LDW: begin
                        pc_inc   = 1'b1;
                        state_nx = ST_OPHI;
                    end
                    OP_LDIND: begin
                        mem_addr = adr;
                        state_nx = ST_EXEC;
                    end
                    OP_SAVE: begin
                        mem_addr = adr;
                        mem_we   = 1'b1;
                    end
                    OP_MOVE: begin
                        rf_we    = 1'b1;
                        rf_waddr = dec.dst;
                        rf_wdata = rf_rdata;
                    end
                    OP_HALT: state_nx = ST_HALT;
                    OP_RSVD: illegal = 1'b1;
                    default: ;
                endcase
            end
            ST_OPHI: begin
                pc_inc   = 1'b1;
                state_nx = ST_OPLO;
                if (ir_pair == PAIR_ADR) adr_hi_ld = 1'b1;
                else begin
                    rf_we    = 1'b1;
                    rf_waddr = pair_hi_idx(ir_pair);
                end
            end
            ST_OPLO: begin
                state_nx = ST_FETCH;
                if (ir_kind == OP_LDW && ir_pair == PAIR_ADR) adr_lo_ld = 1'b1;
                else begin
                    rf_we    = 1'b1;
                    rf_waddr = (ir_kind == OP_LDW) ? pair_lo_idx(ir_pair) : ir_dst;
                end
            end
            ST_EXEC: begin
                rf_we    = 1'b1;
                state_nx = ST_FETCH;
            end
            default: state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_FETCH;
            adr     <= '0;
            ir_kind <= OP_NOP;
            ir_dst  <= '0;
            ir_pair <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_DECODE) begin
                ir_kind <= dec.kind;
                ir_dst  <= dec.dst;
                ir_pair <= dec.pair;
            end
            if (adr_hi_ld) adr[ADDR_W-1:HALF_W] <= mem_rdata;
            if (adr_lo_ld) adr[HALF_W-1:0]      <= mem_rdata;
        end
    end

    assign busy   = (state != ST_FETCH) && (state != ST_HALT);
    assign halted = (state == ST_HALT);

    // R1: leaving reset, the block sits at an opcode fetch from address zero
    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && !busy && !halted && !rf_we && !mem_we));

    // R9: halt is sticky and silent
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !rf_we && !mem_we && $stable(mem_addr)));

    // R10: a reserved opcode writes nothing and retires at once
    assert_rsvd_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!rf_we && !mem_we));
    assert_rsvd_retire_R10: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (!busy && !halted && !illegal));

    // R7: a store never coincides with a register write
    assert_store_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, mem_we}));

    // R12: a new opcode fetch is always followed by a busy decode cycle
    assert_fetch_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !halted) |=> (busy || halted));
endmodule

// File: tb/sim_seq_fetch_load.sv
module sim_seq_fetch_load;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata, rf_rdata, rf_wdata;
    logic [2:0]  rf_raddr, rf_waddr;
    logic        mem_we, rf_we, busy, halted, illegal;

    always #5 clk = ~clk;

    seq_fetch_load u0 (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_we(rf_we), .busy(busy), .halted(halted), .illegal(illegal)
    );

    // environment: synchronous memory and register file
    logic [7:0] mem [0:65535];
    logic [7:0] regs [0:7];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        if (rf_we) regs[rf_waddr] <= rf_wdata;
    end
    assign rf_rdata = regs[rf_raddr];

    // scoreboard
    localparam int K_RF = 0, K_MEM = 1, K_ILL = 2, K_HALT = 3;
    typedef struct {
        int          kind;
        logic [15:0] a;
        logic [7:0]  d;
        int          req;
    } item_t;
    item_t exp_q[$];
    int    pending = 0;
    int    n_checks = 0, n_err = 0;
    int    fetch_cnt = 0, ninstr = 0;
    logic  prev_h = 1'b0;

    logic [7:0]  mreg [0:7];
    logic [7:0]  mdl_mem [0:65535];
    logic [15:0] madr, wp;

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [15:0] a, input logic [7:0] d, input int req);
        item_t it;
        it.kind = kind; it.a = a; it.d = d; it.req = req;
        exp_q.push_back(it);
        pending++;
    endtask

    task automatic observe(input int kind, input logic [15:0] a, input logic [7:0] d);
        item_t it;
        if (exp_q.size() == 0) begin
            chk(1'b0, 0, "unexpected event kind", kind, 32'hFFFF_FFFF);
            return;
        end
        it = exp_q.pop_front();
        pending--;
        chk(it.kind == kind && it.a == a && it.d == d, it.req, "event kind/addr/data",
            {kind[7:0], a, d}, {it.kind[7:0], it.a, it.d});
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!busy && !halted) fetch_cnt++;
            if (rf_we)            observe(K_RF, {13'b0, rf_waddr}, rf_wdata);
            if (mem_we)           observe(K_MEM, mem_addr, mem_wdata);
            if (illegal)          observe(K_ILL, 16'h0, 8'h0);
            if (halted && !prev_h) observe(K_HALT, 16'h0, 8'h0);
        end
        prev_h = rst ? 1'b0 : halted;
    end

    // driver: assembles a program and pushes the expected results
    task automatic emit(input logic [7:0] b);
        mem[wp] = b;
        wp = wp + 16'd1;
    endtask

    task automatic exp_rf(input logic [2:0] r, input logic [7:0] v, input int req);
        push(K_RF, {13'b0, r}, v, req);
        mreg[r] = v;
    endtask

    task automatic op_ldi(input logic [2:0] r, input logic [7:0] v);   // R3
        emit(8'h00 | {5'b0, r}); emit(v); exp_rf(r, v, 3); ninstr++;
    endtask

    task automatic op_ldw(input logic [1:0] p, input logic [7:0] h, input logic [7:0] l); // R5 R6
        logic [2:0] hi;
        emit(8'h10 | {6'b0, p}); emit(h); emit(l); ninstr++;
        if (p == 2'b11) madr = {h, l};
        else begin
            hi = (p == 2'd0) ? 3'd4 : (p == 2'd1) ? 3'd6 : 3'd2;
            exp_rf(hi, h, 5);
            exp_rf(hi + 3'd1, l, 5);
        end
    endtask

    task automatic op_ind(input logic [2:0] r);                        // R4
        emit(8'h08 | {5'b0, r}); exp_rf(r, mdl_mem[madr], 4); ninstr++;
    endtask

    task automatic op_save(input logic [2:0] r);                       // R7, address from R6
        emit(8'h28 | {5'b0, r}); push(K_MEM, madr, mreg[r], 7);
        mdl_mem[madr] = mreg[r]; ninstr++;
    endtask

    task automatic op_move(input logic [2:0] q, input logic [2:0] r);  // R8
        emit({2'b01, q, r}); exp_rf(r, mreg[q], 8); ninstr++;
    endtask

    task automatic op_rsvd(input logic [7:0] b);                       // R10
        emit(b); push(K_ILL, 16'h0, 8'h0, 10); ninstr++;
    endtask

    task automatic op_nop(input logic [7:0] b);                        // R11
        emit(b); ninstr++;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 65536; i++) begin
            mem[i] = 8'h00;
            mdl_mem[i] = 8'h00;
        end
        for (int i = 0; i < 8; i++) begin
            regs[i] = 8'h00;
            mreg[i] = 8'h00;
        end
        wp = 16'h0; madr = 16'h0; ninstr = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, 0, "watchdog expired", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin : main
        logic [15:0] halt_pc;
        // ---------------- phase A: function tests ----------------
        clear_all();
        op_ldi(3'd4, 8'h5A);
        op_ldi(3'd0, 8'h81);
        op_ldw(2'd0, 8'h12, 8'h34);
        op_ldw(2'd1, 8'h9A, 8'hBC);
        op_ldw(2'd2, 8'h55, 8'h66);
        op_ldw(2'd3, 8'h80, 8'h10);   // R6: ADR = 0x8010, not 0x1080
        op_save(3'd6);
        op_ind(3'd3);
        op_nop(8'h30); op_nop(8'hE5); op_nop(8'hFE); op_nop(8'hD9);
        op_nop(8'h21); op_nop(8'hF3); op_nop(8'hF9);
        op_rsvd(8'h80); op_rsvd(8'h1C); op_rsvd(8'h14); op_rsvd(8'hC7);
        op_rsvd(8'hD2); op_rsvd(8'hDD); op_rsvd(8'hFC);
        op_move(3'd5, 3'd1);
        op_move(3'd4, 3'd4);
        op_save(3'd1);
        op_ind(3'd0);
        op_ldw(2'd3, 8'h12, 8'h34);
        op_save(3'd7);
        emit(8'hFF); push(K_HALT, 16'h0, 8'h0, 9); ninstr++;
        halt_pc = wp;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mem_addr == 16'h0 && !busy && !halted && !illegal && !rf_we && !mem_we, 1,
            "reset outputs", {mem_addr, 4'b0, busy, halted, rf_we, mem_we}, 32'h0);
        fetch_cnt = 0;
        rst = 1'b0;
        wait (halted === 1'b1);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            // R9: stays halted, silent, address frozen
            chk(halted && !busy && !rf_we && !mem_we && mem_addr == halt_pc, 9,
                "halt hold", {mem_addr, 3'b0, halted, busy, rf_we, mem_we}, {halt_pc, 8'h10});
        end
        chk(pending == 0, 9, "phase A items left", pending, 0);
        // R12: one non-busy fetch cycle per instruction
        chk(fetch_cnt == ninstr, 12, "fetch cycle count", fetch_cnt, ninstr);

        // ---------------- phase B: PC wrap ----------------
        @(negedge clk);
        rst = 1'b1;
        clear_all();
        for (int i = 0; i < 21845; i++)
            op_ldw(2'd2, i[7:0] ^ 8'h5C, i[15:8] ^ 8'hA3);
        // R2: opcode at 0xFFFF, its operand is the first opcode byte at 0x0000
        op_ldi(3'd4, 8'h12);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(mem_addr == 16'h0 && !busy && !halted, 1, "reset after halt",
            {mem_addr, 6'b0, busy, halted}, 32'h0);
        rst = 1'b0;
        wait (pending == 0);
        @(negedge clk);
        // R2: the next opcode fetch comes from 0x0001
        chk(!busy && mem_addr == 16'h0001, 2, "fetch after wrap", {busy, mem_addr}, 32'h0001);
        chk(!halted && !illegal, 2, "no fault on wrap", {halted, illegal}, 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule